// File: doc/BRIEF.md
# Five-Pin General-Purpose I/O Controller with Latched Status

This block manages five general-purpose pads through a small 16-bit register file reached by an 8-bit index. Each pad is either an input or an output. One per-pin bit has a different meaning depending on the pin's direction. On an input it selects which pad level counts as active. On an output it selects push-pull drive or open-drain drive, and open-drain is done by switching the output enable. A separate pin-data register holds the values that output pins drive.

Each input is either level-following or edge-latched. A level-following input shows its synchronized, polarity-adjusted value in the status register. An edge-latched input sets its status bit when the input goes from inactive to active. That bit stays set until software writes a zero to it. Pad inputs pass through a two-flop synchronizer before any other use. One synchronous reset covers both the power-up reset and the register reset. The register read port is combinational.

Top module: `gpio5_ctrl`

## Requirements
- R1: After reset the registers read back as follows: index 4Ch (direction, bit=1 input) reads 001Fh, index 4Eh (polarity/drive) reads FFFFh, index 50h (latch enable) reads 0000h, index 54h (status) reads 0000h, and index 56h (pin data) reads 0000h.
- R2: Bits [15:5] of index 4Eh always read as 1. Bits [15:5] of indexes 4Ch, 50h, 54h and 56h always read as 0, whatever value is written.
- R3: A pin whose direction bit is 1 never enables its pad driver. An output pin whose index-4Eh bit is 0 (push-pull) has pad_oe=1 and pad_out equal to its pin-data bit.
- R4: An output pin whose index-4Eh bit is 1 (open-drain) has pad_out=0. It has pad_oe=1 when its data bit is 0 and pad_oe=0 when its data bit is 1.
- R5: A write to index 56h changes only the data bits of pins whose direction bit is 0. The data bits of input pins keep their previous values.
- R6: For an input pin whose index-50h bit is 0, status reads the pad level after two clock edges of synchronization, XNOR-ed with the polarity bit (polarity 1 = active high, 0 = active low). A change on the pad is not visible after only one edge. Writes to index 54h have no effect on such a bit.
- R7: For an input pin whose index-50h bit is 1, status bit is set on an inactive-to-active transition of the synchronized, polarity-adjusted input. The bit stays set after the input returns to inactive. A pin that stays active after its bit was cleared does not set it again. A pin configured as an output reads status 0.
- R8: A latched status bit is cleared by writing 0 to that bit position at index 54h. Writing 1 leaves the bit unchanged.
- R9: If a latching transition and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: Indexes other than 4Ch, 4Eh, 50h, 54h and 56h read as 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| pad_in | input | 5 | Pad input levels (asynchronous) |
| pad_out | output | 5 | Pad output values |
| pad_oe | output | 5 | Pad output enables |

## Verification
The bench sweeps all 32 direction patterns against several polarity/drive and data patterns. A design that mixed up the meaning of the shared bit would drive an input pad, or pull an open-drain pad high. It also checks that data writes leave input pins untouched.

For level-following inputs, every polarity setting is tried with several pad patterns. Each result is sampled both one and two edges after the pad change. A design with too short a synchronizer, or with inverted polarity, shows the wrong value at one of those samples.

The edge-latched checks cover several cases:
- holding a bit after the input returns to inactive;
- no re-latch while the input stays active after a clear;
- a write of ones that must not clear;
- a partial clear;
- a clear that lands on the same edge as a new transition.

A design that gives priority to the clear in that last case loses the event.

// File: rtl/gpio5_ctrl.sv
module gpio5_ctrl #(
  parameter int NPIN = 5,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] IDX_DIR = 8'h4C,
  parameter logic [AW-1:0] IDX_POL = 8'h4E,
  parameter logic [AW-1:0] IDX_LAT = 8'h50,
  parameter logic [AW-1:0] IDX_STS = 8'h54,
  parameter logic [AW-1:0] IDX_DAT = 8'h56
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  localparam int UW = DW - NPIN;

  logic [NPIN-1:0] dir, pol, lat, dout, sf;
  logic [NPIN-1:0] s1, s2, act_q;
  logic [NPIN-1:0] act, rise, clr, status, wbits;
  wire unused_wdata = ^reg_wdata[DW-1:NPIN];

  assign wbits  = reg_wdata[NPIN-1:0];
  assign act    = ~(s2 ^ pol);
  assign rise   = act & ~act_q & dir & lat;
  assign clr    = (reg_wr && reg_addr == IDX_STS) ? ~wbits : '0;
  assign status = dir & ((lat & sf) | (~lat & act));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir   <= '1;
      pol   <= '1;
      lat   <= '0;
      dout  <= '0;
      sf    <= '0;
      s1    <= '0;
      s2    <= '0;
      act_q <= '0;
    end else begin
      s1    <= pad_in;
      s2    <= s1;
      act_q <= act;
      sf    <= (sf & ~clr) | rise;
      if (reg_wr) begin
        if (reg_addr == IDX_DIR) dir <= wbits;
        if (reg_addr == IDX_POL) pol <= wbits;
        if (reg_addr == IDX_LAT) lat <= wbits;
        if (reg_addr == IDX_DAT) dout <= (dout & dir) | (wbits & ~dir);
      end
    end
  end

  always_comb begin
    if (reg_addr == IDX_DIR)      reg_rdata = {{UW{1'b0}}, dir};
    else if (reg_addr == IDX_POL) reg_rdata = {{UW{1'b1}}, pol};
    else if (reg_addr == IDX_LAT) reg_rdata = {{UW{1'b0}}, lat};
    else if (reg_addr == IDX_STS) reg_rdata = {{UW{1'b0}}, status};
    else if (reg_addr == IDX_DAT) reg_rdata = {{UW{1'b0}}, dout};
    else                          reg_rdata = '0;
  end

  assign pad_oe  = ~dir & (~pol | ~dout);
  assign pad_out = ~dir & ~pol & dout;
endmodule

// File: rtl/gpio5_ctrl_chk.sv
module gpio5_ctrl_chk #(
  parameter int NPIN = 5,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] IDX_POL = 8'h4E,
  parameter logic [AW-1:0] IDX_STS = 8'h54,
  parameter logic [AW-1:0] IDX_DAT = 8'h56
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] dir,
  input logic [NPIN-1:0] pol,
  input logic [NPIN-1:0] dout,
  input logic [NPIN-1:0] sf
);
  logic [NPIN-1:0] clr_m, keep;
  logic dat_wr;
  assign clr_m  = (reg_wr && reg_addr == IDX_STS) ? ~reg_wdata[NPIN-1:0] : '0;
  assign keep   = sf & ~clr_m;
  assign dat_wr = reg_wr && reg_addr == IDX_DAT;

  assert_input_undriven_R3: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & dir) == '0);

  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (rst)
    (pad_out & pol) == '0);

  assert_input_data_held_R5: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> ((dout ^ $past(dout)) & $past(dir)) == '0);

  assert_latched_kept_R8: assert property (@(posedge clk) disable iff (rst)
    keep != '0 |=> (sf & $past(keep)) == $past(keep));

  assert_pol_upper_ones_R2: assert property (@(posedge clk) disable iff (rst)
    reg_addr == IDX_POL |-> &reg_rdata[DW-1:NPIN]);
endmodule

bind gpio5_ctrl gpio5_ctrl_chk #(
  .NPIN(NPIN), .AW(AW), .DW(DW),
  .IDX_POL(IDX_POL), .IDX_STS(IDX_STS), .IDX_DAT(IDX_DAT)
) u_chk (.*);

// File: tb/sim_gpio5_ctrl.sv
`timescale 1ns/1ps
module sim_gpio5_ctrl;
  logic clk = 0, rst = 1, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [4:0] pad_in = 0, pad_out, pad_oe;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio5_ctrl u0 (.clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
                 .pad_in, .pad_out, .pad_oe);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    step(1);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [4:0] data, p, d, e, prev_v, v;
    logic [4:0] pols [3];
    logic [4:0] pats [5];
    pols[0] = 5'h00; pols[1] = 5'h1F; pols[2] = 5'h15;
    @(negedge clk); step(3); rst = 0;

    rd(8'h4C, r); chk("R1 dir", r, 16'h001F);
    rd(8'h4E, r); chk("R1 pol", r, 16'hFFFF);
    rd(8'h50, r); chk("R1 lat", r, 16'h0000);
    rd(8'h54, r); chk("R1 sts", r, 16'h0000);
    rd(8'h56, r); chk("R1 dat", r, 16'h0000);

    wr(8'h4E, 16'h0000); rd(8'h4E, r); chk("R2 pol upper", r, 16'hFFE0);
    wr(8'h4C, 16'hFFFF); rd(8'h4C, r); chk("R2 dir upper", r, 16'h001F);
    wr(8'h50, 16'hFFE0); rd(8'h50, r); chk("R2 lat upper", r, 16'h0000);
    wr(8'h56, 16'hFFFF); rd(8'h56, r); chk("R2 dat upper", r, 16'h0000);
    rd(8'h00, r); chk("R10 idx00", r, 16'h0000);
    rd(8'h55, r); chk("R10 idx55", r, 16'h0000);
    rd(8'hFF, r); chk("R10 idxFF", r, 16'h0000);

    data = 5'h0B;
    for (int di = 0; di < 32; di++) begin
      for (int pi = 0; pi < 3; pi++) begin
        d = 5'(di); p = pols[pi];
        wr(8'h4C, 16'h0000);
        wr(8'h56, {11'h0, data});
        wr(8'h4E, {11'h0, p});
        wr(8'h4C, {11'h0, d});
        e = ~d & (~p | ~data);
        chk("R3/R4 pad_oe", {11'h0, pad_oe}, {11'h0, e});
        e = ~d & ~p & data;
        chk("R3/R4 pad_out", {11'h0, pad_out}, {11'h0, e});
        wr(8'h56, {11'h0, ~data});
        rd(8'h56, r);
        e = (data & d) | (~data & ~d);
        chk("R5 data mask", r, {11'h0, e});
      end
    end

    wr(8'h4C, 16'h001F); wr(8'h50, 16'h0000);
    pats[0] = 5'h00; pats[1] = 5'h1F; pats[2] = 5'h0A; pats[3] = 5'h15;
    prev_v = pad_in;
    for (int pv = 0; pv < 32; pv++) begin
      p = 5'(pv);
      pats[4] = p;
      wr(8'h4E, {11'h0, p});
      for (int k = 0; k < 5; k++) begin
        v = pats[k];
        pad_in = v;
        step(1);
        rd(8'h54, r); chk("R6 one edge", r, {11'h0, ~(prev_v ^ p)});
        step(1);
        rd(8'h54, r); chk("R6 two edges", r, {11'h0, ~(v ^ p)});
        prev_v = v;
      end
      wr(8'h54, 16'h0000); rd(8'h54, r); chk("R6 write0 ignored", r, {11'h0, ~(prev_v ^ p)});
      wr(8'h54, 16'hFFFF); rd(8'h54, r); chk("R6 write1 ignored", r, {11'h0, ~(prev_v ^ p)});
    end

    wr(8'h4E, 16'hFFFF); wr(8'h50, 16'h001F);
    pad_in = 0; step(3); wr(8'h54, 16'h0000);
    rd(8'h54, r); chk("R8 cleared", r, 16'h0000);
    pad_in = 5'h05; step(3);
    rd(8'h54, r); chk("R7 latch rise", r, 16'h0005);
    pad_in = 0; step(3);
    rd(8'h54, r); chk("R7 held", r, 16'h0005);
    wr(8'h4C, 16'h001E);
    rd(8'h54, r); chk("R7 output reads 0", r, 16'h0004);
    wr(8'h4C, 16'h001F);
    wr(8'h54, 16'h001F); rd(8'h54, r); chk("R8 write1 keeps", r, 16'h0005);
    wr(8'h54, 16'h001B); rd(8'h54, r); chk("R8 partial clear", r, 16'h0001);
    wr(8'h54, 16'h0000); rd(8'h54, r); chk("R8 full clear", r, 16'h0000);

    pad_in = 5'h02;
    step(2);
    reg_addr = 8'h54; reg_wdata = 16'h0000; reg_wr = 1;
    step(1); reg_wr = 0;
    rd(8'h54, r); chk("R9 set wins", r, 16'h0002);
    pad_in = 0; step(3); wr(8'h54, 16'h0000);

    wr(8'h4E, 16'h0000);
    step(3); wr(8'h54, 16'h0000);
    rd(8'h54, r); chk("R7 no relatch while active", r, 16'h0000);
    pad_in = 5'h1F; step(3);
    rd(8'h54, r); chk("R7 inactive low-pol", r, 16'h0000);
    pad_in = 5'h0F; step(3);
    rd(8'h54, r); chk("R7 low-pol fall", r, 16'h0010);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule